// File: doc/BRIEF.md
# Two-Stage Timeout Timebase Prescaler

This block turns a fast reference clock into two periodic strobes for the timeout timers of a serial bus controller. A fine stage counts reference cycles and pulses once every (fine divisor + 1) cycles. Its pulse drives the short timers: idle detection, byte timeout and clock-held-low timeout. A coarse stage counts only fine pulses and pulses once every (coarse divisor + 1) of them. Its pulse drives the long timers: arbitration, transaction and boot/diagnostic timeouts.

Both divisors are loaded through a single-word write port. While a boot-load phase is running, written values are held in shadow copies and the active ratios stay unchanged. When the boot phase ends, the shadow copies take over. After a reset the divisors are 99 and 999. With a 10 ns reference clock this gives a 1 µs fine strobe and a 1 ms coarse strobe.

Top module: `tick_prescaler`

## Requirements
- R1: `fine_tick` is a one-cycle pulse that recurs every N+1 clock cycles, where N is the active fine divisor. Cycle 0 is the first cycle after reset or after a counter restart, and the first pulse appears in cycle N.
- R2: The coarse stage advances only on fine pulses. `coarse_tick` coincides with a `fine_tick` pulse and recurs every (M+1)·(N+1) cycles, where M is the active coarse divisor. Its first pulse is in cycle (M+1)·(N+1)−1.
- R3: After reset, the fine divisor is 99 and the coarse divisor is 999. The first `fine_tick` is therefore in cycle 99 and the first `coarse_tick` in cycle 99999.
- R4: A divisor of 0 makes its stage pulse on every input event. With a fine divisor of 0, `fine_tick` is high in every cycle. With a coarse divisor of 0, `coarse_tick` accompanies every fine pulse.
- R5: When `boot_active` is low, a write (`wr_en`=1) with `wr_sel`=0 sets the fine divisor and with `wr_sel`=1 sets the coarse divisor. The new value is active from the next clock edge. A write that changes an active divisor restarts both counters from zero on that edge.
- R6: Writes made while `boot_active` is high do not change the active divisors. The strobes keep their previous periods and their phase is not disturbed.
- R7: On the clock edge where `boot_active` is sampled low after being high, the values written during the boot phase become active and both counters restart from zero.
- R8: While `rst` is high, both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_active | input | 1 | High while a boot-load phase is running; writes are shadowed |
| wr_en | input | 1 | Divisor write strobe |
| wr_sel | input | 1 | Divisor select: 0 = fine, 1 = coarse |
| wr_data | input | 16 | Divisor value to write |
| fine_tick | output | 1 | Fine (microsecond-class) strobe |
| coarse_tick | output | 1 | Coarse (millisecond-class) strobe |

## Verification
A table of divisor pairs is run after each reprogramming. The pairs include zero in either stage, zero in both, and small unequal ratios. For each pair the bench measures the first fine pulse, the fine spacing and the first coarse pulse from the restart edge. This separates an off-by-one in either terminal count from a coarse stage that counts reference cycles instead of fine pulses, and it shows whether a write restarts the counters. The reset defaults are timed over a full coarse period. A boot phase then checks two things: that shadowed writes leave the running period untouched, and that the pending values and a restart appear exactly on the edge where the boot phase ends.

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV_W = 16,
  parameter logic [DIV_W-1:0] FINE_RST = 16'd99,
  parameter logic [DIV_W-1:0] COARSE_RST = 16'd999
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_active,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             fine_tick,
  output logic             coarse_tick
);

  logic [DIV_W-1:0] sh_f, sh_c, act_f, act_c, cnt_f, cnt_c;
  logic [DIV_W-1:0] sh_f_n, sh_c_n, act_f_n, act_c_n;
  logic             restart;

  assign sh_f_n  = (wr_en && !wr_sel) ? wr_data : sh_f;
  assign sh_c_n  = (wr_en &&  wr_sel) ? wr_data : sh_c;
  assign act_f_n = boot_active ? act_f : sh_f_n;
  assign act_c_n = boot_active ? act_c : sh_c_n;
  assign restart = (act_f_n != act_f) || (act_c_n != act_c);

  assign fine_tick   = !rst && (cnt_f == act_f);
  assign coarse_tick = fine_tick && (cnt_c == act_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_f  <= FINE_RST;
      sh_c  <= COARSE_RST;
      act_f <= FINE_RST;
      act_c <= COARSE_RST;
    end else begin
      sh_f  <= sh_f_n;
      sh_c  <= sh_c_n;
      act_f <= act_f_n;
      act_c <= act_c_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_f <= '0;
      cnt_c <= '0;
    end else if (fine_tick) begin
      cnt_f <= '0;
      cnt_c <= coarse_tick ? '0 : cnt_c + 1'b1;
    end else begin
      cnt_f <= cnt_f + 1'b1;
    end
  end

  AST_FINE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_f <= act_f));  // R1
  AST_COARSE_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt_c <= act_c));  // R2
  AST_BACK_TO_BACK_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fine_tick) && fine_tick) |-> (act_f == '0));  // R4
  AST_BOOT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(boot_active)) |-> ($stable(act_f) && $stable(act_c)));  // R6
  AST_RESTART_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(act_f) || !$stable(act_c))) |-> (cnt_f == '0 && cnt_c == '0));  // R5
  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |-> (!fine_tick && !coarse_tick));  // R8

endmodule

// File: tb/tick_prescaler_bench.sv
module tick_prescaler_bench;
  logic clk = 0, rst = 1, boot_active = 0, wr_en = 0, wr_sel = 0;
  logic [15:0] wr_data = '0;
  logic fine_tick, coarse_tick;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  tick_prescaler u_tick_prescaler (
    .clk(clk), .rst(rst), .boot_active(boot_active), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .fine_tick(fine_tick), .coarse_tick(coarse_tick));

  // {fine div, coarse div, first fine, fine period, first coarse}
  localparam int VEC [6][5] = '{
    '{0, 0, 0, 1, 0}, '{1, 0, 1, 2, 1}, '{0, 3, 0, 1, 3},
    '{3, 2, 3, 4, 11}, '{4, 4, 4, 5, 24}, '{7, 1, 7, 8, 15}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  // called at a negedge that is cycle 0
  task automatic measure(int limit, output int f1, output int f2, output int c1);
    f1 = -1; f2 = -1; c1 = -1;
    for (int c = 0; c < limit; c++) begin
      if (fine_tick && f1 < 0) f1 = c;
      else if (fine_tick && f2 < 0) f2 = c;
      if (coarse_tick && c1 < 0) c1 = c;
      if (f2 >= 0 && c1 >= 0) break;
      @(negedge clk);
    end
  endtask

  task automatic period(output int p);
    int t0;
    t0 = -1; p = -1;
    for (int c = 0; c < 200; c++) begin
      if (fine_tick) begin
        if (t0 >= 0) begin p = c - t0; break; end
        t0 = c;
      end
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <200000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int f1, f2, c1, p;
    repeat (3) @(negedge clk);
    chk("R8 fine low in reset", int'(fine_tick), 0);
    chk("R8 coarse low in reset", int'(coarse_tick), 0);
    rst = 0;
    measure(100100, f1, f2, c1);
    chk("R3 default first fine", f1, 99);
    chk("R3 default fine period", f2 - f1, 100);
    chk("R3 default first coarse", c1, 99999);

    foreach (VEC[i]) begin
      wr(1'b1, 16'(VEC[i][1]));
      wr(1'b0, 16'(VEC[i][0]));
      measure(200, f1, f2, c1);
      chk("R1 first fine after R5 write", f1, VEC[i][2]);
      chk("R1 fine period", f2 - f1, VEC[i][3]);
      chk("R2 first coarse", c1, VEC[i][4]);
    end

    wr(1'b0, 16'd0);
    chk("R4 fine every cycle", int'(fine_tick), 1);
    @(negedge clk);
    chk("R4 fine every cycle next", int'(fine_tick), 1);

    wr(1'b1, 16'd1);
    wr(1'b0, 16'd4);
    @(negedge clk); boot_active = 1;
    wr(1'b0, 16'd1);
    wr(1'b1, 16'd2);
    period(p);
    chk("R6 fine period kept in boot", p, 5);
    boot_active = 0;
    @(negedge clk);
    measure(100, f1, f2, c1);
    chk("R7 first fine after boot end", f1, 1);
    chk("R7 fine period after boot end", f2 - f1, 2);
    chk("R7 first coarse after boot end", c1, 5);

    rst = 1;
    @(negedge clk);
    chk("R8 fine low while reset", int'(fine_tick), 0);
    rst = 0;
    measure(200, f1, f2, c1);
    chk("R3 fine default restored", f1, 99);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule